// File: doc/BRIEF.md
# Inter-core mailbox FIFO pair

This block lets two processor cores pass 32-bit words to each other. It holds two single-clock FIFOs, each eight entries deep. One carries words from core 0 to core 1, and the other carries words from core 1 to core 0. Each core reaches the block through a register port. Every access on a port carries a core-ID bit, and that bit decides which FIFO the access refers to. A core always pushes into the FIFO leading away from it and pops from the FIFO leading toward it, so both cores use the same offsets.

Each core has a small status word. It shows whether incoming data is waiting and whether the outgoing FIFO has room. It also holds two sticky error flags: one records a push that was refused because the outgoing FIFO was full, and the other records a pop that found the incoming FIFO empty. Each core has an interrupt line. The line is high while incoming data waits or while either of that core's error flags is set. Read data appears one clock after the read access.

Top module: `mbx_pair`

## Requirements
- R1: After synchronous reset, both FIFOs are empty, both error flags of both cores are clear, `irq` is 0 and both read-data outputs are 0.
- R2: A write by core c to byte offset 0x4 appends the word to the FIFO leading to the other core. Reads by the other core at offset 0x8 return the words in first-in first-out order, each on the read-data output of the accessing port one clock after the access.
- R3: The core-ID on each access selects the view, not the port. A word written by core c never appears in core c's own incoming FIFO, whichever port carries the access.
- R4: A read at offset 0x0 returns the accessing core's status: bit 0 = incoming data valid, bit 1 = outgoing FIFO has a free entry, bit 2 = write-overflow flag, bit 3 = read-underflow flag. All other bits are 0. The value reflects the state before the access.
- R5: An outgoing FIFO accepts 8 words. A further write while it is full discards the word and sets that core's write-overflow flag. Bit 1 of the status reads 0 while the FIFO is full.
- R6: A read at offset 0x8 while the incoming FIFO is empty returns 0, changes no FIFO, and sets that core's read-underflow flag.
- R7: Both error flags stay set until that core writes any value to offset 0x0, which clears both of them. The other core's flags are not affected by that write.
- R8: `irq[c]` equals valid OR write-overflow OR read-underflow of core c. The free-entry bit does not contribute.
- R9: A push and a pop on the same FIFO in the same cycle are both handled, and the occupancy stays consistent. Acceptance is judged on the occupancy before the cycle: a push into a full FIFO is refused even when a pop happens in the same cycle, and a pop of an empty FIFO underflows even when a push happens in the same cycle.
- R10: When both ports access in the same cycle with the same core-ID, port 0's access takes effect. Port 1's access has no effect, and port 1's read data is 0 in the next cycle.
- R11: Writes to offset 0x8, reads of offset 0x4, and any access to another offset (including 0xC and unaligned offsets) change nothing, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_en | input | 1 | Port 0 access strobe |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_id | input | 1 | Core on whose behalf port 0 accesses |
| p0_addr | input | 4 | Port 0 byte offset |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data, one clock after access |
| p1_en | input | 1 | Port 1 access strobe |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_id | input | 1 | Core on whose behalf port 1 accesses |
| p1_addr | input | 4 | Port 1 byte offset |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data, one clock after access |
| irq | output | 2 | Interrupt per core, indexed by core number |

## Verification
Some situations need two accesses to the same FIFO in the same cycle. One is a full FIFO that is pushed and popped in one clock. Another is an empty FIFO that receives a push while the other core pops it. A third is two ports presenting the same core-ID. None of these occurs in an ordinary exchange of messages. The bench first fills a FIFO to exactly eight entries and drains one to exactly zero. It then issues the colliding accesses on both ports in a single clock. A long stretch of random accesses on both ports with random IDs follows, and a queue-based model is compared against both read-data outputs and the interrupts on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned NCORE     = 2;
    localparam int unsigned OFS_STAT  = 0;
    localparam int unsigned OFS_TXW   = 4;
    localparam int unsigned OFS_RXR   = 8;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_TXW  = 2'd1,
        SEL_RXR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     act;
        logic     wr;
        reg_sel_e sel;
    } core_cmd_t;

    // bit 0 valid, bit 1 ready, bit 2 overflow, bit 3 underflow
    typedef struct packed {
        logic roe;
        logic wof;
        logic rdy;
        logic vld;
    } mbx_stat_t;

    localparam int unsigned STAT_W = $bits(mbx_stat_t);

    function automatic reg_sel_e sel_of(input logic [31:0] ofs);
        if (ofs == OFS_STAT)      return SEL_STAT;
        else if (ofs == OFS_TXW)  return SEL_TXW;
        else if (ofs == OFS_RXR)  return SEL_RXR;
        else                      return SEL_NONE;
    endfunction

    function automatic logic stat_irq(input mbx_stat_t s);
        return s.vld | s.wof | s.roe;
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CAP);
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r9_push_pop_balance: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty) |=> (cnt == $past(cnt)));

    a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CAP);

endmodule

// File: rtl/mbx_core.sv
module mbx_core
    import mbx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  core_cmd_t     cmd,
    input  logic [DW-1:0] wdata,
    input  logic          tx_full,
    input  logic          rx_empty,
    input  logic [DW-1:0] rx_head,
    output logic          tx_push,
    output logic [DW-1:0] tx_data,
    output logic          rx_pop,
    output logic [DW-1:0] rd_val,
    output mbx_stat_t     stat,
    output logic          irq
);
    logic wr_tx, rd_rx, clr;
    logic wof_q, roe_q;

    assign wr_tx = cmd.act &&  cmd.wr && (cmd.sel == SEL_TXW);
    assign rd_rx = cmd.act && !cmd.wr && (cmd.sel == SEL_RXR);
    assign clr   = cmd.act &&  cmd.wr && (cmd.sel == SEL_STAT);

    assign tx_push = wr_tx;
    assign tx_data = wdata;
    assign rx_pop  = rd_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            wof_q <= 1'b0;
            roe_q <= 1'b0;
        end else if (clr) begin
            wof_q <= 1'b0;
            roe_q <= 1'b0;
        end else begin
            if (wr_tx && tx_full)  wof_q <= 1'b1;
            if (rd_rx && rx_empty) roe_q <= 1'b1;
        end
    end

    always_comb begin
        stat.roe = roe_q;
        stat.wof = wof_q;
        stat.rdy = !tx_full;
        stat.vld = !rx_empty;
    end

    always_comb begin
        rd_val = '0;
        if (cmd.act && !cmd.wr) begin
            case (cmd.sel)
                SEL_STAT: rd_val = {{(DW-STAT_W){1'b0}}, stat};
                SEL_RXR:  rd_val = rx_empty ? '0 : rx_head;
                default:  rd_val = '0;
            endcase
        end
    end

    assign irq = stat_irq(stat);

    a_r7_wof_sticky: assert property (@(posedge clk) disable iff (rst)
        (wof_q && !clr) |=> wof_q);

    a_r7_roe_sticky: assert property (@(posedge clk) disable iff (rst)
        (roe_q && !clr) |=> roe_q);

    a_r5_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && tx_full) |=> stat.wof);

    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && rx_empty) |-> (rd_val == '0));

    a_r8_ready_not_irq: assert property (@(posedge clk) disable iff (rst)
        (!stat.vld && !stat.wof && !stat.roe) |-> !irq);

endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p0_en,
    input  logic              p0_we,
    input  logic              p0_id,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_en,
    input  logic              p1_we,
    input  logic              p1_id,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [1:0]        irq
);
    localparam int NPORT = 2;

    logic              pe [NPORT];
    logic              pw [NPORT];
    logic              pid[NPORT];
    logic [ADDR_W-1:0] pa [NPORT];
    logic [DATA_W-1:0] pd [NPORT];
    logic              pg [NPORT];
    logic [DATA_W-1:0] prd_q[NPORT];

    assign pe[0] = p0_en;  assign pe[1] = p1_en;
    assign pw[0] = p0_we;  assign pw[1] = p1_we;
    assign pid[0] = p0_id; assign pid[1] = p1_id;
    assign pa[0] = p0_addr; assign pa[1] = p1_addr;
    assign pd[0] = p0_wdata; assign pd[1] = p1_wdata;

    // port 0 wins a same-core collision
    assign pg[0] = pe[0];
    assign pg[1] = pe[1] && !(pe[0] && (pid[0] == pid[1]));

    core_cmd_t         c_cmd  [NCORE];
    logic [DATA_W-1:0] c_wd   [NCORE];
    logic              c_push [NCORE];
    logic [DATA_W-1:0] c_txd  [NCORE];
    logic              c_pop  [NCORE];
    logic [DATA_W-1:0] c_rd   [NCORE];
    mbx_stat_t         c_stat [NCORE];
    logic              c_irq  [NCORE];

    logic              f_full [NCORE];
    logic              f_empty[NCORE];
    logic [DATA_W-1:0] f_head [NCORE];

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            c_cmd[c] = '{act: 1'b0, wr: 1'b0, sel: SEL_NONE};
            c_wd[c]  = '0;
            for (int p = NPORT - 1; p >= 0; p--) begin
                if (pg[p] && (pid[p] == 1'(c))) begin
                    c_cmd[c].act = 1'b1;
                    c_cmd[c].wr  = pw[p];
                    c_cmd[c].sel = sel_of(32'(pa[p]));
                    c_wd[c]      = pd[p];
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NCORE; g++) begin : g_lane
            // FIFO g carries words away from core g
            mbx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
                .clk       (clk),
                .rst       (rst),
                .push      (c_push[g]),
                .push_data (c_txd[g]),
                .pop       (c_pop[NCORE-1-g]),
                .head      (f_head[g]),
                .full      (f_full[g]),
                .empty     (f_empty[g])
            );

            mbx_core #(.DW(DATA_W)) u_core (
                .clk      (clk),
                .rst      (rst),
                .cmd      (c_cmd[g]),
                .wdata    (c_wd[g]),
                .tx_full  (f_full[g]),
                .rx_empty (f_empty[NCORE-1-g]),
                .rx_head  (f_head[NCORE-1-g]),
                .tx_push  (c_push[g]),
                .tx_data  (c_txd[g]),
                .rx_pop   (c_pop[g]),
                .rd_val   (c_rd[g]),
                .stat     (c_stat[g]),
                .irq      (c_irq[g])
            );

            assign irq[g] = c_irq[g];
        end

        for (g = 0; g < NPORT; g++) begin : g_port
            always_ff @(posedge clk) begin
                if (rst)
                    prd_q[g] <= '0;
                else if (pg[g] && !pw[g])
                    prd_q[g] <= c_rd[pid[g]];
                else
                    prd_q[g] <= '0;
            end
        end
    endgenerate

    assign p0_rdata = prd_q[0];
    assign p1_rdata = prd_q[1];

    a_r10_port1_dropped: assert property (@(posedge clk) disable iff (rst)
        (p0_en && p1_en && (p0_id == p1_id)) |=> (p1_rdata == '0));

    a_r11_write_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (p0_en && p0_we) |=> (p0_rdata == '0));

endmodule

// File: tb/sim_mbx_pair.sv
`timescale 1ns/1ps
module sim_mbx_pair;
    localparam int DW    = 32;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        p0_en, p0_we, p0_id, p1_en, p1_we, p1_id;
    logic [3:0]  p0_addr, p1_addr;
    logic [31:0] p0_wdata, p1_wdata;
    logic [31:0] p0_rdata, p1_rdata;
    logic [1:0]  irq;

    always #4 clk = ~clk;

    mbx_pair #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(4)) u0 (
        .clk(clk), .rst(rst),
        .p0_en(p0_en), .p0_we(p0_we), .p0_id(p0_id), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_en(p1_en), .p1_we(p1_we), .p1_id(p1_id), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .irq(irq)
    );

    int unsigned n_vec = 0, n_bad = 0;
    logic [31:0] q0[$];
    logic [31:0] q1[$];
    bit          wof_m[2];
    bit          roe_m[2];
    logic [31:0] exp_rd[2];
    logic [1:0]  exp_irq;

    function automatic int qsize(int f);
        return (f == 0) ? q0.size() : q1.size();
    endfunction

    function automatic logic [31:0] qhead(int f);
        if (qsize(f) == 0) return 32'd0;
        return (f == 0) ? q0[0] : q1[0];
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic setp(int p, bit we, bit id, logic [3:0] a, logic [31:0] d);
        if (p == 0) begin
            p0_en = 1; p0_we = we; p0_id = id; p0_addr = a; p0_wdata = d;
        end else begin
            p1_en = 1; p1_we = we; p1_id = id; p1_addr = a; p1_wdata = d;
        end
    endtask

    task automatic idle();
        p0_en = 0; p0_we = 0; p0_id = 0; p0_addr = 0; p0_wdata = 0;
        p1_en = 0; p1_we = 0; p1_id = 0; p1_addr = 0; p1_wdata = 0;
    endtask

    task automatic model_step();
        bit en[2], we[2], id[2], g[2];
        logic [3:0] ad[2];
        logic [31:0] wd[2];
        int sz[2];
        bit do_pop[2], do_push[2], set_w[2], set_r[2], clr[2];
        logic [31:0] pdat[2];
        en[0] = p0_en; we[0] = p0_we; id[0] = p0_id; ad[0] = p0_addr; wd[0] = p0_wdata;
        en[1] = p1_en; we[1] = p1_we; id[1] = p1_id; ad[1] = p1_addr; wd[1] = p1_wdata;
        g[0] = en[0];
        g[1] = en[1] && !(en[0] && id[0] == id[1]);
        for (int f = 0; f < 2; f++) begin
            sz[f] = qsize(f);
            do_pop[f] = 0; do_push[f] = 0; set_w[f] = 0; set_r[f] = 0; clr[f] = 0;
            pdat[f] = 0;
        end
        for (int p = 0; p < 2; p++) begin
            int c;
            int o;
            c = int'(id[p]);
            o = 1 - c;
            exp_rd[p] = 32'd0;
            if (g[p]) begin
                if (!we[p]) begin
                    if (ad[p] == 4'd0)
                        exp_rd[p] = {28'd0, roe_m[c], wof_m[c], (sz[c] < DEPTH), (sz[o] > 0)};
                    else if (ad[p] == 4'd8) begin
                        exp_rd[p] = qhead(o);
                        if (sz[o] > 0) do_pop[o] = 1; else set_r[c] = 1;
                    end
                end else begin
                    if (ad[p] == 4'd4) begin
                        if (sz[c] < DEPTH) begin do_push[c] = 1; pdat[c] = wd[p]; end
                        else set_w[c] = 1;
                    end else if (ad[p] == 4'd0) clr[c] = 1;
                end
            end
        end
        if (do_pop[0]) void'(q0.pop_front());
        if (do_pop[1]) void'(q1.pop_front());
        if (do_push[0]) q0.push_back(pdat[0]);
        if (do_push[1]) q1.push_back(pdat[1]);
        for (int c = 0; c < 2; c++) begin
            if (clr[c]) begin wof_m[c] = 0; roe_m[c] = 0; end
            if (set_w[c]) wof_m[c] = 1;
            if (set_r[c]) roe_m[c] = 1;
            exp_irq[c] = (qsize(1 - c) > 0) || wof_m[c] || roe_m[c];
        end
    endtask

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "p0_rdata", p0_rdata, exp_rd[0]);
        chk(tag, "p1_rdata", p1_rdata, exp_rd[1]);
        chk(tag, "irq (R8)", {30'd0, irq}, {30'd0, exp_irq});
        idle();
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        wof_m[0] = 0; wof_m[1] = 0; roe_m[0] = 0; roe_m[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "p0_rdata", p0_rdata, 0);
        chk("R1", "p1_rdata", p1_rdata, 0);
        chk("R1", "irq", {30'd0, irq}, 0);
        setp(0, 0, 0, 4'd0, 0); setp(1, 0, 1, 4'd0, 0); cyc("R1");

        // R2 basic transfer core0 -> core1
        for (int i = 0; i < 3; i++) begin setp(0, 1, 0, 4'd4, 32'hA000_0000 + i); cyc("R2"); end
        setp(1, 0, 1, 4'd0, 0); cyc("R4");
        for (int i = 0; i < 3; i++) begin setp(1, 0, 1, 4'd8, 0); cyc("R2"); end

        // R3 swapped ports carry the views
        setp(0, 1, 1, 4'd4, 32'h1111_1111); setp(1, 1, 0, 4'd4, 32'h0000_0000 + 32'h2222); cyc("R3");
        setp(0, 0, 1, 4'd8, 0); setp(1, 0, 0, 4'd8, 0); cyc("R3");
        setp(0, 0, 0, 4'd8, 0); cyc("R3");

        // R5 fill and overflow core0
        for (int i = 0; i < 9; i++) begin setp(0, 1, 0, 4'd4, 32'hB000_0000 + i); cyc("R5"); end
        setp(0, 0, 0, 4'd0, 0); setp(1, 0, 1, 4'd0, 0); cyc("R5");

        // R9 full FIFO pushed and popped in the same cycle
        setp(0, 1, 0, 4'd4, 32'hC0C0_0001); setp(1, 0, 1, 4'd8, 0); cyc("R9");
        setp(0, 1, 0, 4'd4, 32'hC0C0_0002); setp(1, 0, 1, 4'd8, 0); cyc("R9");

        // R7 clear core0 flags
        setp(0, 1, 0, 4'd0, 32'hFFFF_FFFF); cyc("R7");
        setp(0, 0, 0, 4'd0, 0); cyc("R7");

        // R6 drain then underflow
        for (int i = 0; i < 8; i++) begin setp(1, 0, 1, 4'd8, 0); cyc("R2"); end
        setp(1, 0, 1, 4'd8, 0); cyc("R6");
        setp(1, 0, 1, 4'd0, 0); setp(0, 1, 0, 4'd0, 0); cyc("R7");
        setp(1, 1, 1, 4'd0, 0); cyc("R7");
        setp(1, 0, 1, 4'd0, 0); cyc("R7");

        // R9 empty FIFO pushed and popped in the same cycle
        setp(0, 1, 0, 4'd4, 32'hD00D_0001); setp(1, 0, 1, 4'd8, 0); cyc("R9");
        setp(1, 0, 1, 4'd8, 0); cyc("R9");
        setp(1, 1, 1, 4'd0, 0); cyc("R9");

        // R10 same core-ID on both ports
        setp(0, 0, 0, 4'd0, 0); setp(1, 1, 0, 4'd4, 32'hEEEE_0001); cyc("R10");
        setp(0, 1, 1, 4'd4, 32'hEEEE_0002); setp(1, 1, 1, 4'd4, 32'hEEEE_0003); cyc("R10");
        setp(0, 0, 0, 4'd8, 0); setp(1, 0, 0, 4'd8, 0); cyc("R10");

        // R11 unmapped or wrong-direction accesses
        setp(0, 1, 0, 4'd8, 32'h5555_5555); setp(1, 0, 1, 4'd4, 0); cyc("R11");
        setp(0, 0, 0, 4'd12, 0); setp(1, 1, 1, 4'd12, 32'h7); cyc("R11");
        setp(0, 0, 1, 4'd1, 0); setp(1, 0, 0, 4'd4, 0); cyc("R11");
        setp(0, 0, 0, 4'd0, 0); setp(1, 0, 1, 4'd0, 0); cyc("R11");

        // R9 random traffic on both ports
        for (int i = 0; i < 600; i++) begin
            for (int p = 0; p < 2; p++) begin
                if (($urandom % 4) != 0) begin
                    logic [3:0] a;
                    int r;
                    r = $urandom % 10;
                    a = (r < 4) ? 4'd4 : (r < 7) ? 4'd8 : (r < 9) ? 4'd0 : 4'd12;
                    setp(p, (a == 4'd4) ? 1'b1 : (a == 4'd8) ? 1'b0 : 1'($urandom % 2),
                         1'($urandom % 2), a, $urandom);
                end
            end
            cyc("R9");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule